// File: doc/BRIEF.md
# Two-Wire Memory Target Front End

This block turns a two-wire serial bus into simple requests for a byte-wide memory back end. It watches oversampled clock and data lines and finds start and stop conditions. It answers only to its own device address, which is a fixed type prefix plus three strap pins. It takes a two-byte word address, then either accepts data bytes or streams bytes back to the bus master. On the data line it only ever pulls low (open drain). The back end sees four single-cycle pulses: address load, byte write, byte read and commit.

The block keeps the word pointer itself. Writes advance the pointer inside a 32-byte page. Reads advance it across the whole space. A read with no address phase therefore continues from where the last access ended. While the back end reports an internal write in progress, the block refuses its device address. A master can then poll until it sees an acknowledge.

Top module: `twi_mem_target`

## Requirements
- R1: After reset the data line is released and no back-end request is raised. A falling data edge with the clock high (start) begins reception of a device byte. A rising data edge with the clock high (stop) returns the block to idle.
- R2: The block changes its data-line drive only while the synchronized clock is low, i.e. after a clock falling edge. Input bits are taken on the clock rising edge.
- R3: The device byte is received MSB first as 1,0,1,0, strap[2], strap[1], strap[0], then direction (1 = read). If the first seven bits differ, the block does not acknowledge and ignores every later byte until the next start.
- R4: In a write, the block acknowledges the device byte, the high address byte, the low address byte and every data byte by pulling the data line low during the ninth clock.
- R5: The word address is the low 5 bits of the high address byte followed by the low byte (13 bits). `mem_load` pulses once the low byte is in, with `mem_addr` holding that address. Each data byte gives one `mem_wr` pulse with its address. Only the low 5 address bits advance, so they wrap inside the 32-byte page.
- R6: `mem_commit` pulses on a stop only if at least one data byte was written since the last start. An address-only access or a read never commits.
- R7: While `mem_busy` is high, the device byte is not acknowledged. Once busy clears, the same device byte is acknowledged.
- R8: A repeated start after the two address bytes, followed by a read device byte, returns first the byte at the address just loaded.
- R9: Read data goes out MSB first. Each bit appears after a clock falling edge. Each bit the master acknowledges fetches the next byte. The address advances over the full space, so 0x1FFF is followed by 0x0000. A not-acknowledge releases the line and ends the read.
- R10: A read with no address phase starts at the byte after the last byte written or read.
- R11: A start or stop in the middle of a byte drops that byte, resets the bit count and raises no back-end request. The word pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line (wired bus level) |
| strap_id | input | 3 | Strap bits compared with the device byte |
| sda_pull_low | output | 1 | 1 pulls the data line low |
| mem_busy | input | 1 | Back end is in an internal write cycle |
| mem_addr | output | AW | Word pointer sent with every request |
| mem_load | output | 1 | Address load pulse |
| mem_wr | output | 1 | Byte write pulse |
| mem_wdata | output | 8 | Byte to write |
| mem_rd | output | 1 | Byte read pulse; data expected one cycle later |
| mem_rdata | input | 8 | Read data, registered by the back end |
| mem_commit | output | 1 | Commit pulse on stop after a write |

## Verification
Two cases are hard to reach from the ports. The first is a refused device address while the back end is busy. The bench runs a back-end model whose busy window opens on each commit. It sends a device byte right after the stop, while that window is still open, and then polls until an acknowledge comes back. The second is an aborted byte. The stimulus cuts one byte short with a stop and another with a repeated start. It then does a read with no address phase, and the returned byte shows that the pointer kept its value.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire memory target.
package twi_pkg;
    // Fixed device-type prefix of the device byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol phases of the target.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
// Synchronizes the raw clock and data lines and detects bus events.
// Assumes clk runs at least 8x faster than the serial clock.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;

    logic [LINES-1:0][STAGES-1:0] chain;
    logic [LINES-1:0]             raw;
    logic                         scl_q;
    logic                         sda_q;

    assign raw = {scl_raw, sda_raw};

    // Shift each line through its synchronizer chain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                chain[i] <= {chain[i][STAGES-2:0], raw[i]};
            end
        end
    end

    assign scl_lvl = chain[1][STAGES-1];
    assign sda_lvl = chain[0][STAGES-1];

    // Keep last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_lvl;
            sda_q <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign start_evt = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/twi_addr_ptr.sv
// Word pointer: loads a new address, steps inside a page for writes,
// steps across the full space for reads. Load has priority.
module twi_addr_ptr #(
    parameter int AW = 13,
    parameter int PB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_page,
    input  logic          inc_lin,
    output logic [AW-1:0] ptr
);
    localparam logic [PB-1:0] PG_ONE = PB'(1);

    // Update the pointer from the highest-priority request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc_page) begin
            ptr <= {ptr[AW-1:PB], ptr[PB-1:0] + PG_ONE};
        end else if (inc_lin) begin
            ptr <= ptr + AW'(1);
        end
    end

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !load) |=> ptr[AW-1:PB] == $past(ptr[AW-1:PB])); // R5

    AST_LIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_lin && !inc_page && !load && (&ptr)) |=> ptr == '0); // R9
endmodule

// File: rtl/twi_mem_target.sv
// Two-wire bus target front end for a byte memory. Handles start/stop,
// device byte match, two address bytes, acknowledges, writes and
// sequential reads. Assumes clk >= 8x serial clock and that mem_rdata
// is valid the cycle after mem_rd.
module twi_mem_target
    import twi_pkg::*;
#(
    parameter int AW          = 13,
    parameter int PB          = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [2:0]    strap_id,
    output logic          sda_pull_low,
    input  logic          mem_busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_load,
    output logic          mem_wr,
    output logic [7:0]    mem_wdata,
    output logic          mem_rd,
    input  logic [7:0]    mem_rdata,
    output logic          mem_commit
);
    localparam int HI_BITS = AW - 8;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    twi_state_t        state;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [7:0]        txbyte;
    logic [HI_BITS-1:0] addr_hi;
    logic              drv;
    logic              wrote;
    logic              rd_sel;
    logic              rd_pend;
    logic              load_q;
    logic              byte_end;
    logic              dev_hit;
    logic              ptr_load;
    logic              wr_now;
    logic              rd_now;
    logic [AW-1:0]     ptr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    // Decode request pulses from the current phase and bus events.
    always_comb begin
        byte_end = scl_fall && (cnt == 4'd8);
        dev_hit  = (shreg[7:1] == {DEV_TYPE, strap_id}) && !mem_busy;
        ptr_load = byte_end && (state == ST_ALO);
        wr_now   = byte_end && (state == ST_WR);
        rd_now   = (byte_end && (state == ST_DEV) && dev_hit && shreg[0])
                || (scl_rise && (cnt == 4'd8) && (state == ST_RD) && !sda_lvl);
    end

    twi_addr_ptr #(.AW(AW), .PB(PB)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val({addr_hi, shreg}),
        .inc_page(wr_now),
        .inc_lin (rd_now),
        .ptr     (ptr)
    );

    // Delayed load pulse and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            rd_pend <= 1'b0;
            txbyte  <= '0;
        end else begin
            load_q  <= ptr_load;
            rd_pend <= rd_now;
            if (rd_pend) txbyte <= mem_rdata;
        end
    end

    // Protocol sequencer: bit count, shift register, line drive, phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            addr_hi <= '0;
            drv     <= 1'b0;
            wrote   <= 1'b0;
            rd_sel  <= 1'b0;
        end else if (start_evt) begin
            state <= ST_DEV;
            cnt   <= '0;
            drv   <= 1'b0;
            wrote <= 1'b0;
        end else if (stop_evt) begin
            state <= ST_IDLE;
            cnt   <= '0;
            drv   <= 1'b0;
            wrote <= 1'b0;
        end else if (state != ST_IDLE) begin
            if (scl_rise) begin
                if (cnt != 4'd9) cnt <= cnt + 4'd1;
                if (cnt < 4'd8 && state != ST_RD) shreg <= {shreg[6:0], sda_lvl};
                if (cnt == 4'd8 && state == ST_RD) rd_sel <= !sda_lvl;
            end else if (scl_fall) begin
                case (cnt)
                    4'd8: begin
                        if (state == ST_RD) begin
                            drv <= 1'b0;
                        end else if (state == ST_DEV && !dev_hit) begin
                            state <= ST_IDLE;
                            drv   <= 1'b0;
                        end else begin
                            drv <= 1'b1;
                            if (state == ST_DEV) rd_sel  <= shreg[0];
                            if (state == ST_AHI) addr_hi <= shreg[HI_BITS-1:0];
                            if (state == ST_WR)  wrote   <= 1'b1;
                        end
                    end
                    4'd9: begin
                        cnt <= '0;
                        case (state)
                            ST_DEV: begin
                                state <= rd_sel ? ST_RD : ST_AHI;
                                drv   <= rd_sel ? ~txbyte[7] : 1'b0;
                            end
                            ST_AHI: begin
                                state <= ST_ALO;
                                drv   <= 1'b0;
                            end
                            ST_ALO, ST_WR: begin
                                state <= ST_WR;
                                drv   <= 1'b0;
                            end
                            ST_RD: begin
                                if (rd_sel) begin
                                    drv <= ~txbyte[7];
                                end else begin
                                    state <= ST_IDLE;
                                    drv   <= 1'b0;
                                end
                            end
                            default: drv <= 1'b0;
                        endcase
                    end
                    default: begin
                        if (state == ST_RD && cnt != 4'd0) drv <= ~txbyte[3'd7 - cnt[2:0]];
                    end
                endcase
            end
        end
    end

    assign sda_pull_low = drv;
    assign mem_addr     = ptr;
    assign mem_load     = load_q;
    assign mem_wr       = wr_now;
    assign mem_wdata    = shreg;
    assign mem_rd       = rd_now;
    assign mem_commit   = stop_evt && wrote;

    AST_DRV_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_low != $past(sda_pull_low)) |-> !scl_lvl); // R2

    AST_MISS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_end && shreg[7:4] != DEV_TYPE) |=> (state == ST_IDLE && !sda_pull_low)); // R3

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_load, mem_wr, mem_rd, mem_commit})); // R6

    AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV && byte_end && mem_busy) |=> !sda_pull_low); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (cnt == 4'd0 && state == ST_DEV && !mem_wr)); // R11

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd9); // R1
endmodule

// File: tb/twi_mem_target_tb_top.sv
module twi_mem_target_tb_top;
    localparam int AW       = 13;
    localparam int HALF     = 10;
    localparam int BUSY_CYC = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [1:0] K_LOAD = 2'd0, K_WR = 2'd1, K_COMMIT = 2'd2;

    typedef struct packed {
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull_low, mem_busy, mem_load, mem_wr, mem_rd, mem_commit;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    wire sda_bus = sda_m & ~sda_pull_low;

    int n_chk = 0;
    int n_fail = 0;
    int r2_bad = 0;
    int busy_cnt;
    logic [7:0] bmem [int];
    ev_t expq[$];

    twi_mem_target #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .strap_id(STRAP), .sda_pull_low(sda_pull_low), .mem_busy(mem_busy),
        .mem_addr(mem_addr), .mem_load(mem_load), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_commit(mem_commit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Back-end model: storage, busy window after commit, registered read.
    assign mem_busy = busy_cnt != 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt  <= 0;
            mem_rdata <= 8'h00;
        end else begin
            if (mem_commit) busy_cnt <= BUSY_CYC;
            else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
            if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
            if (mem_rd) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
        end
    end

    // Scoreboard monitor: compare each back-end request with the queue.
    logic prev_drv = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_pull_low != prev_drv && scl_m) r2_bad++;
            prev_drv = sda_pull_low;
            if (mem_load || mem_wr || mem_commit) begin
                ev_t got;
                got.kind = mem_commit ? K_COMMIT : (mem_wr ? K_WR : K_LOAD);
                got.addr = mem_commit ? '0 : mem_addr;
                got.data = mem_wr ? mem_wdata : 8'h00;
                if (expq.size() == 0) begin
                    check(1'b0, "R11 unexpected back-end request", 32'(got), 32'h0);
                end else begin
                    ev_t exp;
                    exp = expq.pop_front();
                    check(got == exp, (exp.kind == K_COMMIT) ? "R6 commit" : "R5 load/write",
                          32'(got), 32'(exp));
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF/2);
        ack = !sda_bus; wait_clk(HALF/2);
        scl_m = 1'b0; wait_clk(2);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wait_clk(HALF);
            scl_m = 1'b1; wait_clk(HALF/2);
            d[i] = sda_bus; wait_clk(HALF/2);
            scl_m = 1'b0; wait_clk(2);
        end
        send_bit(!give_ack);
    endtask

    function automatic logic [7:0] dev_byte(input logic rw);
        return {4'b1010, STRAP, rw};
    endfunction

    // Poll with the device byte until it is acknowledged.
    task automatic acquire(input logic rw);
        logic ack;
        for (int t = 0; t < 20; t++) begin
            bus_start();
            send_byte(dev_byte(rw), ack);
            if (ack) return;
            bus_stop();
            wait_clk(20);
        end
        check(1'b0, "R7 device never acknowledged", 0, 1);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        logic ack;
        expq.push_back('{K_LOAD, a, 8'h00});
        send_byte(8'(a >> 8), ack);
        check(ack, "R4 high address ack", 32'(ack), 1);
        send_byte(a[7:0], ack);
        check(ack, "R4 low address ack", 32'(ack), 1);
    endtask

    task automatic wr_txn(input logic [AW-1:0] a, input int n, input logic [31:0] d);
        logic ack;
        acquire(1'b0);
        send_addr(a);
        for (int k = 0; k < n; k++) begin
            logic [4:0] lo;
            lo = a[4:0] + 5'(k);
            expq.push_back('{K_WR, {a[AW-1:5], lo}, d[31-8*k -: 8]});
            send_byte(d[31-8*k -: 8], ack);
            check(ack, "R4 data ack", 32'(ack), 1);
        end
        expq.push_back('{K_COMMIT, '0, 8'h00});
        bus_stop();
    endtask

    task automatic read_bytes(input int n, input logic [31:0] e, input string req);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            recv_byte(d, k != n - 1);
            check(d == e[31-8*k -: 8], req, 32'(d), 32'(e[31-8*k -: 8]));
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [AW-1:0] a, input int n, input logic [31:0] e, input string req);
        logic ack;
        acquire(1'b0);
        send_addr(a);
        bus_start();
        send_byte(dev_byte(1'b1), ack);
        check(ack, "R8 read device ack", 32'(ack), 1);
        read_bytes(n, e, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] d;
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset state
        check(!sda_pull_low, "R1 released after reset", 32'(sda_pull_low), 0);
        check(!(mem_load | mem_wr | mem_rd | mem_commit), "R1 no request after reset",
              {28'h0, mem_load, mem_wr, mem_rd, mem_commit}, 0);

        // R3: wrong strap and wrong type prefix are refused; later bytes ignored
        bus_start();
        send_byte({4'b1010, 3'b011, 1'b0}, ack);
        check(!ack, "R3 strap mismatch nack", 32'(ack), 0);
        send_byte(8'h00, ack);
        check(!ack, "R3 following byte ignored", 32'(ack), 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b0}, ack);
        check(!ack, "R3 type prefix mismatch nack", 32'(ack), 0);
        bus_stop();

        // R4 R5 R6: write four bytes at 0x0000
        wr_txn(13'h0000, 4, 32'h6B7C8D9E);

        // R7: poll during busy window is refused, then accepted
        bus_start();
        send_byte(dev_byte(1'b0), ack);
        check(!ack, "R7 nack while busy", 32'(ack), 0);
        bus_stop();
        acquire(1'b0);
        check(1'b1, "R7 ack after busy", 1, 1);
        bus_stop();

        wr_txn(13'h0123, 3, 32'hA1B2C300);
        // R5: page wrap 0x1FE,0x1FF,0x1E0,0x1E1
        wr_txn(13'h01FE, 4, 32'h11223344);
        wr_txn(13'h1FFF, 1, 32'h5A000000);

        // R8: random read; R9 sequential, wrap and full-space rollover
        rd_txn(13'h0123, 3, 32'hA1B2C300, "R8 random read data");
        rd_txn(13'h01E0, 2, 32'h33440000, "R9 page wrap read back");
        rd_txn(13'h01FE, 2, 32'h11220000, "R9 sequential read");
        rd_txn(13'h1FFF, 2, 32'h5A6B0000, "R9 rollover to zero");

        // R10: current-address read continues after last access
        acquire(1'b1);
        read_bytes(2, 32'h7C8D0000, "R10 current address read");

        // R11: byte cut by stop, byte cut by repeated start
        acquire(1'b0);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte(dev_byte(1'b1), ack);
        check(ack, "R11 ack after mid-byte restart", 32'(ack), 1);
        recv_byte(d, 1'b0);
        check(d == 8'h9E, "R11 pointer kept after abort", 32'(d), 32'h9E);
        bus_stop();

        // R6: address only, then stop: no commit
        acquire(1'b0);
        send_addr(13'h0040);
        bus_stop();
        wait_clk(40);
        check(expq.size() == 0, "R6 all expected requests seen, none extra", expq.size(), 0);
        check(r2_bad == 0, "R2 drive changed only with clock low", r2_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule